// File: doc/BRIEF.md
# Banked Memory Configuration Unit

This unit sits beside an 8-bit processor with a 16-bit address bus and tells the memory system where each access goes. A small register window at a fixed base address holds a live configuration word, four stored preconfiguration words and a RAM configuration word. For every processor access the unit decodes the address against the live configuration. The result is a two-bit RAM bank number and, for the top 16 kB quarter, a ROM enable and a ROM identifier. A common-RAM window at the bottom of the address space can force bank 0.

Software switches memory layouts in one store. It writes a preconfiguration word ahead of time, and later writes to that word's load address, which copies it into the live configuration. The RAM configuration word also carries the video RAM bank, which is brought out continuously, and a RAM block field that is only stored. All outputs are registered and update one clock after an access.

Top module: `bank_cfg_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0. In that state `acc_vld`, `bank_sel`, `rom_en`, `rom_id`, `common_hit`, `vid_bank` and `rdata` are 0, which gives bank 0 with the kernel ROM visible.
- R2: The register window is the 16 bytes at `WIN_BASE` (0xD500). Offset 0 is the live configuration, offsets 1 to 4 are preconfigurations A to D, and offset 5 is the RAM configuration. A read returns the stored byte. Offsets 6 to 15 read 0, and a write to offsets 10 to 15 changes no register.
- R3: For an access outside the common window, `bank_sel` equals bits 7:6 of the live configuration as it stood in the access cycle.
- R4: Bits 5:4 of the live configuration select the source for addresses 0xC000 to 0xFFFF. Code 00 selects the kernel ROM, 01 the internal function ROM and 10 the external function ROM, each giving `rom_en`=1 and `rom_id` equal to the code. Code 11 selects RAM and gives `rom_en`=0. Addresses below 0xC000 always give `rom_en`=0 and `rom_id`=0.
- R5: A write to offset 6+k (k = 0 to 3) copies preconfiguration k into the live configuration in that same clock edge, and the written data is ignored.
- R6: Bits 3:2 of the RAM configuration set the common window. Code 00 means none, 01 means addresses below 0x1000, 10 below 0x2000 and 11 below 0x4000. An access inside the window gives `common_hit`=1 and `bank_sel`=0.
- R7: `vid_bank` equals bits 7:6 of the RAM configuration at all times.
- R8: `acc_vld`, `bank_sel`, `rom_en`, `rom_id` and `common_hit` are registered. They reflect an access (`cpu_en`=1) one clock later and hold their values while no access occurs.
- R9: Read data appears on `rdata` one clock after a read access (`cpu_rw`=1). A read outside the register window gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | Access strobe for this cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| acc_vld | output | 1 | Decoded outputs belong to an access |
| bank_sel | output | 2 | RAM bank for the access |
| rom_en | output | 1 | Access targets a ROM |
| rom_id | output | 2 | Which ROM when `rom_en` is set |
| common_hit | output | 1 | Common window overrode the bank |
| vid_bank | output | 2 | Video RAM bank |

## Verification
Some properties are checked by assertions on every clock. The common window always forces bank 0 and only ever hits the lowest quarter. A ROM enable only ever follows a top-quarter address. The live configuration changes only after a write, and the decoded outputs follow the access strobe and hold between accesses. Other behaviour shows only in the bench's sweeps:
- the exact ROM identifier for each top-quarter code;
- the window edges for each size code, with the bank field taken over all four values;
- the readback of every register offset;
- the load offsets copying the correct preconfiguration word.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int OFS_CFG    = 0;
  localparam int OFS_PRE0   = 1;
  localparam int NUM_PRE    = 4;
  localparam int OFS_RAMCFG = OFS_PRE0 + NUM_PRE;
  localparam int OFS_LOAD0  = OFS_RAMCFG + 1;
  localparam int WIN_BITS   = 4;

  typedef enum logic [1:0] {
    TOP_KERNEL = 2'b00,
    TOP_INTFN  = 2'b01,
    TOP_EXTFN  = 2'b10,
    TOP_RAM    = 2'b11
  } top_src_e;

  typedef struct packed {
    logic [1:0] bank;
    top_src_e   top;
    logic [3:0] spare;
  } cfg_word_t;

  typedef struct packed {
    logic [1:0] vid;
    logic [1:0] block;
    logic [1:0] common;
    logic [1:0] spare;
  } ramcfg_word_t;
endpackage

// File: rtl/bcu_regs.sv
module bcu_regs
  import bcu_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] WIN_BASE = 16'hD500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] ramcfg_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [DATA_W-1:0]   pre_q [NUM_PRE];
  logic [DATA_W-1:0]   cfg_q, ramcfg_q, cfg_d;
  logic [WIN_BITS-1:0] ofs;
  logic                hit, wr;

  assign ofs = addr[WIN_BITS-1:0];
  assign hit = en && (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign wr  = hit && !rw;

  genvar k;
  generate
    for (k = 0; k < NUM_PRE; k++) begin : g_pre
      always_ff @(posedge clk) begin
        if (rst)
          pre_q[k] <= '0;
        else if (wr && ofs == WIN_BITS'(OFS_PRE0 + k))
          pre_q[k] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    cfg_d = cfg_q;
    if (wr && ofs == WIN_BITS'(OFS_CFG))
      cfg_d = wdata;
    for (int j = 0; j < NUM_PRE; j++)
      if (wr && ofs == WIN_BITS'(OFS_LOAD0 + j))
        cfg_d = pre_q[j];
  end

  always_comb begin
    rd_o = '0;
    if (ofs == WIN_BITS'(OFS_CFG))
      rd_o = cfg_q;
    if (ofs == WIN_BITS'(OFS_RAMCFG))
      rd_o = ramcfg_q;
    for (int j = 0; j < NUM_PRE; j++)
      if (ofs == WIN_BITS'(OFS_PRE0 + j))
        rd_o = pre_q[j];
    if (!hit)
      rd_o = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      ramcfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      if (wr && ofs == WIN_BITS'(OFS_RAMCFG))
        ramcfg_q <= wdata;
    end
  end

  assign cfg_o    = cfg_q;
  assign ramcfg_o = ramcfg_q;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = WIN_BASE[ADDR_W-1:WIN_BITS];
endmodule

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  cfg_word_t         cfg,
  input  ramcfg_word_t      ramcfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        bank,
  output logic              rom_en,
  output logic [1:0]        rom_id,
  output logic              common_hit
);
  localparam int SHIFT_BASE = ADDR_W - 4;

  logic top_q;
  logic in_win;

  assign top_q = (addr[ADDR_W-1 -: 2] == 2'b11);

  always_comb begin
    case (ramcfg.common)
      2'b01:   in_win = (addr >> SHIFT_BASE) == '0;
      2'b10:   in_win = (addr >> (SHIFT_BASE + 1)) == '0;
      2'b11:   in_win = (addr >> (SHIFT_BASE + 2)) == '0;
      default: in_win = 1'b0;
    endcase
  end

  assign common_hit = in_win;
  assign bank       = in_win ? 2'b00 : cfg.bank;
  assign rom_en     = top_q && (cfg.top != TOP_RAM);
  assign rom_id     = rom_en ? cfg.top : 2'b00;
endmodule

// File: rtl/bank_cfg_unit.sv
module bank_cfg_unit
  import bcu_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] WIN_BASE = 16'hD500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_en,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_vld,
  output logic [1:0]        bank_sel,
  output logic              rom_en,
  output logic [1:0]        rom_id,
  output logic              common_hit,
  output logic [1:0]        vid_bank
);
  logic [DATA_W-1:0] cfg_q, ramcfg_q, rd_d;
  logic [1:0]        bank_d, rom_id_d;
  logic              rom_en_d, common_d;
  cfg_word_t         cfg_w;
  ramcfg_word_t      ramcfg_w;

  bcu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE)) u_regs (
    .clk(clk), .rst(rst), .en(cpu_en), .rw(cpu_rw), .addr(cpu_addr),
    .wdata(cpu_wdata), .cfg_o(cfg_q), .ramcfg_o(ramcfg_q), .rd_o(rd_d)
  );

  assign cfg_w    = cfg_word_t'(cfg_q);
  assign ramcfg_w = ramcfg_word_t'(ramcfg_q);

  bcu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cfg(cfg_w), .ramcfg(ramcfg_w), .addr(cpu_addr),
    .bank(bank_d), .rom_en(rom_en_d), .rom_id(rom_id_d), .common_hit(common_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      acc_vld    <= 1'b0;
      bank_sel   <= '0;
      rom_en     <= 1'b0;
      rom_id     <= '0;
      common_hit <= 1'b0;
    end else begin
      acc_vld <= cpu_en;
      if (cpu_en) begin
        bank_sel   <= bank_d;
        rom_en     <= rom_en_d;
        rom_id     <= rom_id_d;
        common_hit <= common_d;
        if (cpu_rw)
          rdata <= rd_d;
      end
    end
  end

  assign vid_bank = ramcfg_w.vid;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_en,
  input logic              cpu_rw,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              acc_vld,
  input logic [1:0]        bank_sel,
  input logic              rom_en,
  input logic [1:0]        rom_id,
  input logic              common_hit,
  input logic [7:0]        cfg
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!acc_vld && bank_sel == 2'b00 && !rom_en && rom_id == 2'b00 && !common_hit));

  assert_cfg_only_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cfg)) |-> $past(cpu_en && !cpu_rw));

  assert_bank_follows_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc_vld && !common_hit) |-> bank_sel == $past(cfg[7:6]));

  assert_rom_top_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc_vld && rom_en) |-> $past(cpu_addr[ADDR_W-1 -: 2]) == 2'b11);

  assert_common_bank0_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && common_hit) |-> (bank_sel == 2'b00 && !rom_en));

  assert_common_low_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc_vld && common_hit) |-> $past(cpu_addr[ADDR_W-1 -: 2]) == 2'b00);

  assert_valid_follows_en_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_vld == $past(cpu_en));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cpu_en)) |-> ($stable(bank_sel) && $stable(rom_en) && $stable(rom_id) && $stable(common_hit)));
endmodule

bind bank_cfg_unit bcu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
  .acc_vld(acc_vld), .bank_sel(bank_sel), .rom_en(rom_en), .rom_id(rom_id),
  .common_hit(common_hit), .cfg(cfg_q)
);

// File: tb/bank_cfg_unit_bench.sv
`timescale 1ns/1ps
module bank_cfg_unit_bench;
  localparam logic [15:0] WB = 16'hD500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_en = 1'b0, cpu_rw = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  rdata;
  logic        acc_vld, rom_en, common_hit;
  logic [1:0]  bank_sel, rom_id, vid_bank;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bank_cfg_unit u_bank_cfg_unit (
    .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .rdata(rdata), .acc_vld(acc_vld), .bank_sel(bank_sel),
    .rom_en(rom_en), .rom_id(rom_id), .common_hit(common_hit), .vid_bank(vid_bank)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, register at the rising edge, return at the next falling edge
  task automatic acc(input logic [15:0] a, input logic rw, input logic [7:0] d);
    @(negedge clk);
    cpu_en = 1'b1; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_rw = 1'b1;
  endtask

  task automatic wr(input int ofs, input logic [7:0] d);
    acc(WB + 16'(ofs), 1'b0, d);
  endtask

  task automatic rd_chk(input int ofs, input logic [7:0] exp, input string req);
    acc(WB + 16'(ofs), 1'b1, 8'h00);
    chk(rdata == exp, req, rdata, exp);
  endtask

  function automatic bit in_common(input int c, input logic [15:0] a);
    int lim;
    lim = (c == 1) ? 32'h1000 : (c == 2) ? 32'h2000 : (c == 3) ? 32'h4000 : 0;
    return int'(a) < lim;
  endfunction

  initial begin
    logic [15:0] samp [3];
    logic [15:0] a;
    logic [1:0]  eb, eid;
    bit          eh, er;
    samp[0] = 16'h0100; samp[1] = 16'h1F00; samp[2] = 16'h3F00;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!acc_vld && bank_sel == 0 && !rom_en && rom_id == 0 && !common_hit && vid_bank == 0 && rdata == 0,
        "R1 outputs after reset", {acc_vld, bank_sel, rom_en, rom_id, common_hit, vid_bank}, 0);
    for (int o = 0; o < 6; o++) rd_chk(o, 8'h00, "R1 register clear");
    acc(16'hE000, 1'b1, 8'h00);
    chk(rom_en && rom_id == 0 && bank_sel == 0, "R1 kernel ROM bank 0", {rom_en, rom_id, bank_sel}, 5'b10000);

    // R2 readback of every register with distinct patterns
    for (int o = 0; o < 6; o++) wr(o, 8'h11 * (o + 3));
    for (int o = 0; o < 6; o++) rd_chk(o, 8'h11 * (o + 3), "R2 readback");
    for (int o = 6; o < 16; o++) rd_chk(o, 8'h00, "R2 unused offset reads 0");
    for (int o = 10; o < 16; o++) wr(o, 8'hA5);
    for (int o = 0; o < 6; o++) rd_chk(o, 8'h11 * (o + 3), "R2 unused write ignored");

    // R9 read outside window gives 0; R8 outputs hold while idle
    acc(16'h8000, 1'b1, 8'h00);
    chk(rdata == 0, "R9 read outside window", rdata, 0);
    a = {14'd0, bank_sel};
    repeat (3) @(negedge clk);
    chk(!acc_vld && bank_sel == a[1:0], "R8 hold while idle", {acc_vld, bank_sel}, a[1:0]);

    // R5 load offsets copy preconfigurations
    for (int k = 0; k < 4; k++) wr(1 + k, 8'h40 * k + 8'h10 * ((k + 1) % 4) + 8'(k));
    for (int k = 0; k < 4; k++) begin
      wr(6 + k, 8'hFF);
      rd_chk(0, 8'h40 * k + 8'h10 * ((k + 1) % 4) + 8'(k), "R5 load preconfiguration");
      acc(16'h8000, 1'b1, 8'h00);
      chk(bank_sel == 2'(k), "R5 bank after load", bank_sel, k);
    end

    // R3 R4 R6 R7 sweep: bank x top code x common size x quarter x sample
    for (int c = 0; c < 4; c++) begin
      wr(5, 8'(c * 64 + c * 4 + 16));
      chk(vid_bank == 2'(c), "R7 video bank", vid_bank, c);
      for (int b = 0; b < 4; b++)
        for (int t = 0; t < 4; t++) begin
          wr(0, 8'(b * 64 + t * 16));
          for (int q = 0; q < 4; q++)
            for (int s = 0; s < 3; s++) begin
              a = 16'(q * 16'h4000) + samp[s];
              acc(a, 1'b1, 8'h00);
              eh  = in_common(c, a);
              eb  = eh ? 2'd0 : 2'(b);
              er  = (q == 3) && (t != 3);
              eid = er ? 2'(t) : 2'd0;
              chk(acc_vld, "R8 valid after access", acc_vld, 1);
              chk(common_hit == eh, "R6 common window", common_hit, eh);
              chk(bank_sel == eb, eh ? "R6 forced bank 0" : "R3 bank field", bank_sel, eb);
              chk(rom_en == er && rom_id == eid, "R4 top source", {rom_en, rom_id}, {er, eid});
            end
        end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule